// File: doc/BRIEF.md
# UART Interrupt Enable and Request Logic

This block holds the interrupt enable register of a UART and merges five interrupt sources into a single request line. A byte-wide write port loads the enable register and a read port returns it. The UART datapath supplies status: the receive FIFO fill level, a receiver timeout, pulsed line-error events, transmit FIFO empty, transmit shift register empty, and four modem status pins. The block keeps two kinds of sticky state. Line-error flags are cleared by a line-status read strobe. Modem change flags are set by edges on the synchronized modem pins and cleared by a modem-status read strobe.

A small state machine holds the identity of the highest-priority pending source. Its states are `SRC_NONE`, `SRC_LINE`, `SRC_RXD`, `SRC_TXDONE`, `SRC_TXE` and `SRC_MODEM`. On every clock the machine moves to the state of the highest-priority enabled source that is active, or to `SRC_NONE` when no such source exists. Any state can reach any other state in one cycle. The request output is high in every state except `SRC_NONE`. The current state is driven onto `src_id_o` as the pending-source code.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the enable register reads 0x00, `irq_o` is 0 and `src_id_o` is 0 (`SRC_NONE`).
- R2: Enable register bit positions: bit0 receive, bit1 transmit-empty, bit2 line status, bit3 modem, bit4 transmission complete. Bits 7:5 always read 0 and bits 4:0 read back the last value written. A written value is visible on `reg_rdata_o` in the cycle after the write.
- R3: With bit0 set, a nonzero `rx_level_i` requests an interrupt with code 2 (`SRC_RXD`).
- R4: With bit0 set, `rx_timeout_i` requests code 2 on its own. With bit0 clear, neither receive data nor the timeout has any effect.
- R5: With bit1 set, `tx_fifo_empty_i` high requests code 4 (`SRC_TXE`).
- R6: `line_err_i` carries parity (bit0), framing (bit1), overrun (bit2) and break (bit3) pulses. Each pulse sets a sticky flag on `line_flags_o`. The flags are cleared by `line_rd_i`, and an error in the same cycle as the read is kept. Any set flag with enable bit2 set requests code 1 (`SRC_LINE`). With bit2 clear the flags still record errors but no request is made.
- R7: Each modem pin passes through a two-flop synchronizer. Any change of a synchronized pin sets its sticky flag on `modem_delta_o`. The flags are cleared by `modem_rd_i`. Any set flag with bit3 set requests code 5 (`SRC_MODEM`).
- R8: With bit4 set, code 3 (`SRC_TXDONE`) is requested only when `tx_fifo_empty_i` and `tx_shift_empty_i` are both high.
- R9: `irq_o` is registered. It is the OR of all enabled active sources and drops at the first clock edge after the last of them clears or is disabled.
- R10: When several sources are pending, `src_id_o` follows the priority line status, then receive, then transmission complete, then transmit empty, then modem.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Write strobe for the enable register |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Enable register read value |
| rx_level_i | input | 5 | Receive FIFO fill level |
| rx_timeout_i | input | 1 | Receiver timeout status |
| line_err_i | input | 4 | Line error event pulses |
| line_rd_i | input | 1 | Line status read strobe (clears error flags) |
| tx_fifo_empty_i | input | 1 | Transmit FIFO empty |
| tx_shift_empty_i | input | 1 | Transmit shift register empty |
| modem_i | input | 4 | Asynchronous modem status pins |
| modem_rd_i | input | 1 | Modem status read strobe (clears change flags) |
| line_flags_o | output | 4 | Sticky line error flags |
| modem_delta_o | output | 4 | Sticky modem change flags |
| irq_o | output | 1 | Interrupt request |
| src_id_o | output | 3 | Pending-source code |

## Verification
The assertions take three things for granted. Status inputs other than the modem pins are synchronous to `clk`. Error and read strobes are single-cycle pulses. Modem pins hold each level for at least three clocks, so the synchronizer sees every change. The stimulus drives all inputs on the falling edge and pulses strobes for exactly one cycle. It holds each modem level long enough for the change to settle through the synchronizer, the change flag and the state register before the outputs are sampled. Each check is taken only after that settling time, except the exact-cycle check on request release.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [2:0] {
        SRC_NONE   = 3'd0,
        SRC_LINE   = 3'd1,
        SRC_RXD    = 3'd2,
        SRC_TXDONE = 3'd3,
        SRC_TXE    = 3'd4,
        SRC_MODEM  = 3'd5
    } src_e;

    localparam int EN_RXD    = 0;
    localparam int EN_TXE    = 1;
    localparam int EN_LINE   = 2;
    localparam int EN_MODEM  = 3;
    localparam int EN_TXDONE = 4;
    localparam int EN_USED   = 5;

    typedef struct packed {
        logic line;
        logic rxd;
        logic txdone;
        logic txe;
        logic modem;
    } pend_t;

endpackage

// File: rtl/uart_irq_enreg.sv
module uart_irq_enreg #(
    parameter int REG_W  = 8,
    parameter int USED_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [USED_W-1:0] en_o,
    output logic [REG_W-1:0]  rdata_o
);
    localparam int RSVD_W = REG_W - USED_W;

    logic [USED_W-1:0] en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    en_q <= '0;
        else if (wr_i) en_q <= wdata_i[USED_W-1:0];
    end

    assign en_o    = en_q;
    assign rdata_o = {{RSVD_W{1'b0}}, en_q};

    // R2: written value readable on the next cycle
    p_wr_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> rdata_o[USED_W-1:0] == $past(wdata_i[USED_W-1:0]));

endmodule

// File: rtl/uart_irq_line.sv
module uart_irq_line #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] err_i,
    input  logic         clr_i,
    output logic [W-1:0] flags_o
);
    logic [W-1:0] flags_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (clr_i ? '0 : flags_q) | err_i;
    end

    assign flags_o = flags_q;

    // R6: flags are sticky without a read
    p_line_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (flags_q & $past(flags_q)) == $past(flags_q));
    // R6: a read with no new error empties the flags
    p_line_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && err_i == '0) |=> flags_q == '0);

endmodule

// File: rtl/uart_irq_modem.sv
module uart_irq_modem #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_i,
    input  logic         rd_i,
    output logic [W-1:0] delta_o
);
    logic [STAGES-1:0][W-1:0] stg_q;
    logic [W-1:0]             last_q;
    logic [W-1:0]             change_c;
    logic [W-1:0]             delta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q  <= '0;
            last_q <= '0;
        end else begin
            stg_q  <= {stg_q[STAGES-2:0], pins_i};
            last_q <= stg_q[STAGES-1];
        end
    end

    assign change_c = stg_q[STAGES-1] ^ last_q;

    for (genvar b = 0; b < W; b++) begin : g_delta
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) delta_q[b] <= 1'b0;
            else        delta_q[b] <= (delta_q[b] & ~rd_i) | change_c[b];
        end
    end

    assign delta_o = delta_q;

    // R7: read with no fresh edge clears all change flags
    p_modem_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && change_c == '0) |=> delta_q == '0);
    // R7: flags stay set until read
    p_modem_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> (delta_q & $past(delta_q)) == $past(delta_q));

endmodule

// File: rtl/uart_irq_arb.sv
module uart_irq_arb
    import uart_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  pend_t pend_i,
    output logic  irq_o,
    output src_e  src_o
);
    src_e state_q, state_d;

    always_comb begin
        if      (pend_i.line)   state_d = SRC_LINE;
        else if (pend_i.rxd)    state_d = SRC_RXD;
        else if (pend_i.txdone) state_d = SRC_TXDONE;
        else if (pend_i.txe)    state_d = SRC_TXE;
        else if (pend_i.modem)  state_d = SRC_MODEM;
        else                    state_d = SRC_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SRC_NONE;
        else        state_q <= state_d;
    end

    always_comb begin
        src_o = state_q;
        unique case (state_q)
            SRC_NONE:   irq_o = 1'b0;
            SRC_LINE,
            SRC_RXD,
            SRC_TXDONE,
            SRC_TXE,
            SRC_MODEM:  irq_o = 1'b1;
            default:    irq_o = 1'b0;
        endcase
    end

    // R9: request follows pending sources one cycle later
    p_irq_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_i != '0) |=> irq_o);
    p_irq_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_i == '0) |=> !irq_o);
    // R10: line status beats every other source
    p_prio_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pend_i.line |=> src_o == SRC_LINE);

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int REG_W     = 8,
    parameter int RX_LVL_W  = 5,
    parameter int ERR_W     = 4,
    parameter int MODEM_W   = 4,
    parameter int SYNC_STGS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr_i,
    input  logic [REG_W-1:0]    reg_wdata_i,
    output logic [REG_W-1:0]    reg_rdata_o,
    input  logic [RX_LVL_W-1:0] rx_level_i,
    input  logic                rx_timeout_i,
    input  logic [ERR_W-1:0]    line_err_i,
    input  logic                line_rd_i,
    input  logic                tx_fifo_empty_i,
    input  logic                tx_shift_empty_i,
    input  logic [MODEM_W-1:0]  modem_i,
    input  logic                modem_rd_i,
    output logic [ERR_W-1:0]    line_flags_o,
    output logic [MODEM_W-1:0]  modem_delta_o,
    output logic                irq_o,
    output logic [2:0]          src_id_o
);
    logic [EN_USED-1:0] en;
    pend_t              pend;
    src_e               src;

    uart_irq_enreg #(.REG_W(REG_W), .USED_W(EN_USED)) u_enreg (
        .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .wdata_i(reg_wdata_i),
        .en_o(en), .rdata_o(reg_rdata_o));

    uart_irq_line #(.W(ERR_W)) u_line (
        .clk(clk), .rst_n(rst_n), .err_i(line_err_i), .clr_i(line_rd_i),
        .flags_o(line_flags_o));

    uart_irq_modem #(.W(MODEM_W), .STAGES(SYNC_STGS)) u_modem (
        .clk(clk), .rst_n(rst_n), .pins_i(modem_i), .rd_i(modem_rd_i),
        .delta_o(modem_delta_o));

    always_comb begin
        pend.line   = en[EN_LINE]   & (|line_flags_o);
        pend.rxd    = en[EN_RXD]    & ((rx_level_i != '0) | rx_timeout_i);
        pend.txdone = en[EN_TXDONE] & tx_fifo_empty_i & tx_shift_empty_i;
        pend.txe    = en[EN_TXE]    & tx_fifo_empty_i;
        pend.modem  = en[EN_MODEM]  & (|modem_delta_o);
    end

    uart_irq_arb u_arb (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .irq_o(irq_o), .src_o(src));

    assign src_id_o = src;

    // R8: completion code only after both transmit stages were empty
    p_txdone_both_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (src_id_o == 3'(SRC_TXDONE)) |->
            $past(tx_fifo_empty_i && tx_shift_empty_i && en[EN_TXDONE]));

endmodule

// File: tb/uart_irq_ctrl_bench.sv
module uart_irq_ctrl_bench;

    typedef struct packed {
        logic [4:0] en;
        logic       rxd;
        logic       rto;
        logic       txf;
        logic       txs;
        logic [2:0] id;
    } vec_t;

    localparam int NV = 13;
    // en bits: 0 rx, 1 tx-empty, 2 line, 3 modem, 4 tx-complete
    // id codes: 0 none, 1 line, 2 rx, 3 tx-complete, 4 tx-empty, 5 modem
    localparam vec_t VECS [NV] = '{
        '{5'b00000, 1'b1, 1'b1, 1'b1, 1'b1, 3'd0},
        '{5'b00001, 1'b1, 1'b0, 1'b0, 1'b0, 3'd2},
        '{5'b00001, 1'b0, 1'b1, 1'b0, 1'b0, 3'd2},
        '{5'b00001, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0},
        '{5'b11110, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0},
        '{5'b00010, 1'b0, 1'b0, 1'b1, 1'b0, 3'd4},
        '{5'b10000, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0},
        '{5'b10000, 1'b0, 1'b0, 1'b1, 1'b1, 3'd3},
        '{5'b10000, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0},
        '{5'b10010, 1'b0, 1'b0, 1'b1, 1'b1, 3'd3},
        '{5'b10011, 1'b1, 1'b0, 1'b1, 1'b1, 3'd2},
        '{5'b00011, 1'b0, 1'b0, 1'b1, 1'b1, 3'd4},
        '{5'b11111, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_i = 1'b0;
    logic [7:0] reg_wdata_i = '0;
    logic [7:0] reg_rdata_o;
    logic [4:0] rx_level_i = '0;
    logic       rx_timeout_i = 1'b0;
    logic [3:0] line_err_i = '0;
    logic       line_rd_i = 1'b0;
    logic       tx_fifo_empty_i = 1'b0;
    logic       tx_shift_empty_i = 1'b0;
    logic [3:0] modem_i = '0;
    logic       modem_rd_i = 1'b0;
    logic [3:0] line_flags_o;
    logic [3:0] modem_delta_o;
    logic       irq_o;
    logic [2:0] src_id_o;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    uart_irq_ctrl u_uart_irq_ctrl (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_en(input logic [7:0] v);
        @(negedge clk);
        reg_wr_i = 1'b1; reg_wdata_i = v;
        @(negedge clk);
        reg_wr_i = 1'b0;
        settle();
    endtask

    task automatic pulse_err(input logic [3:0] e);
        @(negedge clk);
        line_err_i = e;
        @(negedge clk);
        line_err_i = '0;
        settle();
    endtask

    task automatic rd_line();
        @(negedge clk);
        line_rd_i = 1'b1;
        @(negedge clk);
        line_rd_i = 1'b0;
        settle();
    endtask

    task automatic rd_modem();
        @(negedge clk);
        modem_rd_i = 1'b1;
        @(negedge clk);
        modem_rd_i = 1'b0;
        settle();
    endtask

    task automatic out_chk(input string req, input logic irq, input logic [2:0] id);
        check(req, {31'd0, irq_o}, {31'd0, irq});
        check(req, {29'd0, src_id_o}, {29'd0, id});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        out_chk("R1", 1'b0, 3'd0);
        check("R1", {24'd0, reg_rdata_o}, 32'h00);
        rst_n = 1'b1;
        settle();
        out_chk("R1", 1'b0, 3'd0);

        // R2: reserved bits read zero, used bits read back
        wr_en(8'hFF);
        check("R2", {24'd0, reg_rdata_o}, 32'h1F);
        wr_en(8'hA5);
        check("R2", {24'd0, reg_rdata_o}, 32'h05);

        // Table: R3 R4 R5 R8 R10 level sources
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            rx_level_i = VECS[i].rxd ? 5'd3 : 5'd0;
            rx_timeout_i = VECS[i].rto;
            tx_fifo_empty_i = VECS[i].txf;
            tx_shift_empty_i = VECS[i].txs;
            wr_en({3'b000, VECS[i].en});
            out_chk("R3/R4/R5/R8/R10 table", VECS[i].id != 3'd0, VECS[i].id);
        end
        rx_level_i = '0; rx_timeout_i = 1'b0;
        tx_fifo_empty_i = 1'b0; tx_shift_empty_i = 1'b0;

        // R6: sticky line errors, ignored with enable clear
        wr_en(8'h00);
        pulse_err(4'b0100);
        check("R6 flag while disabled", {28'd0, line_flags_o}, 32'h4);
        out_chk("R6 disabled", 1'b0, 3'd0);
        rd_line();
        check("R6 clear", {28'd0, line_flags_o}, 32'h0);
        wr_en(8'h04);
        pulse_err(4'b0010);
        out_chk("R6 enabled", 1'b1, 3'd1);
        settle();
        check("R6 sticky", {28'd0, line_flags_o}, 32'h2);
        rd_line();
        out_chk("R6 after read", 1'b0, 3'd0);
        // R6: error in the same cycle as the read survives
        @(negedge clk);
        line_err_i = 4'b1000; line_rd_i = 1'b1;
        @(negedge clk);
        line_err_i = '0; line_rd_i = 1'b0;
        settle();
        check("R6 set beats clear", {28'd0, line_flags_o}, 32'h8);
        rd_line();

        // R7: modem edges
        wr_en(8'h00);
        @(negedge clk); modem_i = 4'b0001;
        settle();
        check("R7 delta disabled", {28'd0, modem_delta_o}, 32'h1);
        out_chk("R7 disabled", 1'b0, 3'd0);
        rd_modem();
        check("R7 cleared", {28'd0, modem_delta_o}, 32'h0);
        wr_en(8'h08);
        @(negedge clk); modem_i = 4'b0101;
        settle();
        out_chk("R7 enabled", 1'b1, 3'd5);
        rd_modem();
        out_chk("R7 after read", 1'b0, 3'd0);

        // R10: priority walk with everything enabled
        wr_en(8'h1F);
        @(negedge clk);
        rx_level_i = 5'd1; tx_fifo_empty_i = 1'b1; tx_shift_empty_i = 1'b1;
        pulse_err(4'b0001);
        out_chk("R10 line first", 1'b1, 3'd1);
        rd_line();
        out_chk("R10 rx next", 1'b1, 3'd2);
        @(negedge clk); rx_level_i = '0;
        settle();
        out_chk("R10 txdone next", 1'b1, 3'd3);
        @(negedge clk); tx_shift_empty_i = 1'b0; modem_i = 4'b0100;
        settle();
        out_chk("R10 txe over modem", 1'b1, 3'd4);
        @(negedge clk); tx_fifo_empty_i = 1'b0;
        settle();
        out_chk("R10 modem last", 1'b1, 3'd5);
        rd_modem();
        out_chk("R10 none", 1'b0, 3'd0);

        // R9: release takes exactly one edge
        wr_en(8'h02);
        @(negedge clk); tx_fifo_empty_i = 1'b1;
        settle();
        out_chk("R9 raised", 1'b1, 3'd4);
        @(negedge clk); tx_fifo_empty_i = 1'b0;
        #1;
        check("R9 held before edge", {31'd0, irq_o}, 32'd1);
        @(negedge clk);
        check("R9 dropped after edge", {31'd0, irq_o}, 32'd0);
        // R9: disabling also drops it
        @(negedge clk); tx_fifo_empty_i = 1'b1;
        settle();
        wr_en(8'h00);
        out_chk("R9 disable", 1'b0, 3'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule